// File: doc/BRIEF.md
# Three-Wire Serial Nonvolatile Memory Slave

This block models a 1 kbit serial memory slave that a host drives with a chip select, a serial clock and a serial data line. It answers on a serial data output that has its own enable, so the pad can float it. The host sends a frame that starts with a 1 bit and carries an opcode and an address. It can read words, read a run of words that wraps around the array, change one word or every word, clear one word or every word, and set or clear a write-protect latch.

The strap input `wide_mode_i` chooses the organization: 64 words of 16 bits with 6-bit addresses, or 128 words of 8 bits with 7-bit addresses. All serial inputs are brought into the system clock domain through a synchronizer, and every action happens on a detected serial-clock rise. A program or clear operation begins when chip select falls after a complete frame. It then keeps the block busy for `CYCLE_CLKS` system clocks, and the block shows its busy or ready state on the data output whenever chip select is high.

Top module: `uwire_eeprom`

## Requirements
- R1: A frame is a 1 start bit, a 2-bit opcode and an address sent MSB first: 6 bits when `wide_mode_i`=1 (16-bit words) and 7 bits when it is 0 (8-bit words). Zero bits before the start bit are skipped.
- R2: Opcode 10 reads. On the rise that takes in the last address bit, the output is enabled and drives 0. Each later rise puts out the next bit of the word, MSB first.
- R3: While chip select stays high, the read goes on with the next address and no further 0 bit. After the top address (63 wide, 127 narrow) it goes to address 0.
- R4: The write-protect latch is clear after reset. Opcode 00 with top address bits 11 sets it, and 00 with 00 clears it. Program and clear operations given while the latch is clear start nothing and change nothing.
- R5: Opcode 01 with a full data field (16 or 8 bits, MSB first) replaces the addressed word when chip select falls. No prior clear is needed.
- R6: Opcode 11 sets the addressed word to all ones.
- R7: Opcode 00 with top address bits 10 sets every word to all ones. With 01 followed by a data field, it loads every word with that data.
- R8: Once an operation has started, the output is enabled whenever chip select is high. It drives 0 for `CYCLE_CLKS` system clocks and 1 after that.
- R9: A 1 clocked in while ready turns that status output off. A 1 clocked in while busy has no effect.
- R10: Frames sent while busy are ignored. A frame cut short by chip select falling executes nothing.
- R11: The output enable is low whenever chip select has been low for more than the synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode_i | input | 1 | 1: 16-bit words, 0: 8-bit words |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Output enable for sdo_o |

## Verification
Each serial-clock rise acts three system clocks after the pin changes: two synchronizer flops, then the registered response. The bench therefore samples the outputs four clocks after it raises the serial clock, still inside the high phase. The status output follows chip select rising within two clocks, and the busy period starts three clocks after chip select falls. The bench checks busy four clocks after selecting and checks ready `CYCLE_CLKS`+20 clocks later. A reference model of bytes, the latch state and the strap predicts each word and whether an operation starts. A per-clock monitor checks the output enable whenever chip select has been low for four or more clocks.

// File: rtl/uwe_pkg.sv
package uwe_pkg;
   typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_DATA, ST_READ, ST_HOLD} uwe_state_e;
   typedef enum logic [1:0] {JOB_CLR, JOB_PROG, JOB_CLR_ALL, JOB_PROG_ALL} uwe_job_e;
   localparam logic [1:0] OP_READ = 2'b10;
   localparam logic [1:0] OP_CLR  = 2'b11;
   localparam logic [1:0] OP_PROG = 2'b01;
   localparam logic [1:0] SUB_UNLOCK   = 2'b11;
   localparam logic [1:0] SUB_LOCK     = 2'b00;
   localparam logic [1:0] SUB_CLR_ALL  = 2'b10;
   localparam logic [1:0] SUB_PROG_ALL = 2'b01;
endpackage

// File: rtl/uwe_sync.sv
module uwe_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] lvl_o,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("uwe_sync: STAGES must be at least 2");
   end

   logic [STAGES:0][W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-1:0], din_i};
   end

   assign lvl_o  = pipe_q[STAGES-1];
   assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
   assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/uwe_timer.sv
module uwe_timer #(
   parameter int CYCLE_CLKS = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   if (CYCLE_CLKS < 1) begin : g_bad_len
      $error("uwe_timer: CYCLE_CLKS must be positive");
   end
   localparam int CW = $clog2(CYCLE_CLKS + 1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             left_q <= '0;
      else if (start_i)       left_q <= CW'(CYCLE_CLKS);
      else if (left_q != '0)  left_q <= left_q - 1'b1;
   end

   assign busy_o = (left_q != '0);

   // R10: the controller never launches a second operation while one runs
   p_start_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);
endmodule

// File: rtl/uwe_array.sv
module uwe_array #(
   parameter int NBYTES = 128
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wide_i,
   input  logic                       we_i,
   input  logic                       all_i,
   input  logic [$clog2(NBYTES)-1:0]  addr_i,
   input  logic [15:0]                wdata_i,
   output logic [15:0]                rdata_o
);
   localparam int AW = $clog2(NBYTES);
   if (NBYTES < 4 || (1 << AW) != NBYTES) begin : g_bad_size
      $error("uwe_array: NBYTES must be a power of two of at least 4");
   end

   logic [NBYTES-1:0][7:0] mem_w;

   for (genvar g = 0; g < NBYTES; g++) begin : g_cell
      localparam logic [AW-1:0] IDX = AW'(g);
      logic       hit;
      logic [7:0] val;
      logic [7:0] cell_q;
      assign hit = all_i | (wide_i ? (addr_i[AW-2:0] == IDX[AW-1:1]) : (addr_i == IDX));
      assign val = (wide_i && !IDX[0]) ? wdata_i[15:8] : wdata_i[7:0];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cell_q <= 8'hFF;
         else if (we_i && hit)    cell_q <= val;
      end
      assign mem_w[g] = cell_q;
   end

   assign rdata_o = wide_i ? {mem_w[{addr_i[AW-2:0], 1'b0}], mem_w[{addr_i[AW-2:0], 1'b1}]}
                           : {mem_w[addr_i], 8'h00};
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
   import uwe_pkg::*;
#(
   parameter int MEM_BITS    = 1024,
   parameter int SYNC_STAGES = 2,
   parameter int CYCLE_CLKS  = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wide_mode_i,
   input  logic cs_i,
   input  logic sclk_i,
   input  logic sdi_i,
   output logic sdo_o,
   output logic sdo_en_o
);
   localparam int NBYTES = MEM_BITS / 8;
   localparam int NAW    = $clog2(NBYTES);
   localparam int WAW    = NAW - 1;
   localparam int CMDW   = NAW + 2;
   localparam logic [4:0] CMD_LAST_W = 5'(WAW + 1);
   localparam logic [4:0] CMD_LAST_N = 5'(NAW + 1);

   if (MEM_BITS % 16 != 0 || NAW < 3 || NAW > 14) begin : g_bad_mem
      $error("uwire_eeprom: MEM_BITS must be a multiple of 16 giving 3 to 14 address bits");
   end

   // ---------------- input synchronization ----------------
   logic [2:0] lvl, rise, fall;
   uwe_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din_i({cs_i, sclk_i, sdi_i}),
      .lvl_o(lvl), .rise_o(rise), .fall_o(fall));

   logic cs_s, cs_fall, sck_rise, sdi_s;
   assign cs_s     = lvl[2];
   assign cs_fall  = fall[2];
   assign sck_rise = rise[1];
   assign sdi_s    = lvl[0];
   logic unused_edges;
   assign unused_edges = ^{rise[2], rise[0], fall[1:0], lvl[1]};

   // ---------------- state ----------------
   uwe_state_e      st_q;
   uwe_job_e        job_q;
   logic [4:0]      cnt_q;
   logic [CMDW-2:0] cmd_q;
   logic [15:0]     din_q, obuf_q;
   logic [NAW-1:0]  addr_q;
   logic [3:0]      bidx_q;
   logic            armed_q, wen_q, stat_q, sdo_q, rd_on_q;
   logic            busy, start;
   logic [15:0]     word;

   // ---------------- frame decode ----------------
   logic            wide;
   logic [CMDW-1:0] nxt;
   logic [1:0]      op_f, sub_f;
   logic [NAW-1:0]  ad_f, addr_mask;
   logic [4:0]      cmd_last, dat_last;
   logic [3:0]      rd_last;

   assign wide      = wide_mode_i;
   assign nxt       = {cmd_q, sdi_s};
   assign op_f      = wide ? nxt[WAW+1:WAW] : nxt[NAW+1:NAW];
   assign sub_f     = wide ? nxt[WAW-1:WAW-2] : nxt[NAW-1:NAW-2];
   assign ad_f      = wide ? {1'b0, nxt[WAW-1:0]} : nxt[NAW-1:0];
   assign addr_mask = wide ? {1'b0, {WAW{1'b1}}} : {NAW{1'b1}};
   assign cmd_last  = wide ? CMD_LAST_W : CMD_LAST_N;
   assign dat_last  = wide ? 5'd15 : 5'd7;
   assign rd_last   = wide ? 4'd15 : 4'd7;

   assign start = cs_fall && (st_q == ST_HOLD) && armed_q && wen_q && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;  job_q <= JOB_CLR;  cnt_q <= '0;  cmd_q <= '0;
         din_q <= '0;  obuf_q <= '0;  addr_q <= '0;  bidx_q <= '0;
         armed_q <= 1'b0;  wen_q <= 1'b0;  stat_q <= 1'b0;  sdo_q <= 1'b0;  rd_on_q <= 1'b0;
      end else if (cs_fall) begin
         st_q    <= ST_IDLE;
         rd_on_q <= 1'b0;
         armed_q <= 1'b0;
         if (start) stat_q <= 1'b1;
      end else if (sck_rise && cs_s) begin
         if (stat_q) begin
            if (sdi_s && !busy) stat_q <= 1'b0;
         end else begin
            case (st_q)
               ST_IDLE: if (sdi_s) begin
                  st_q  <= ST_CMD;
                  cnt_q <= '0;
               end
               ST_CMD: begin
                  cmd_q <= nxt[CMDW-2:0];
                  cnt_q <= cnt_q + 5'd1;
                  if (cnt_q == cmd_last) begin
                     cnt_q  <= '0;
                     addr_q <= ad_f;
                     st_q   <= ST_HOLD;
                     if (op_f == OP_READ) begin
                        st_q <= ST_READ;  rd_on_q <= 1'b1;  sdo_q <= 1'b0;  bidx_q <= '0;
                     end else if (op_f == OP_CLR) begin
                        job_q <= JOB_CLR;  armed_q <= 1'b1;
                     end else if (op_f == OP_PROG) begin
                        job_q <= JOB_PROG;  st_q <= ST_DATA;
                     end else begin
                        case (sub_f)
                           SUB_UNLOCK:  wen_q <= 1'b1;
                           SUB_LOCK:    wen_q <= 1'b0;
                           SUB_CLR_ALL: begin job_q <= JOB_CLR_ALL; armed_q <= 1'b1; end
                           default:     begin job_q <= JOB_PROG_ALL; st_q <= ST_DATA; end
                        endcase
                     end
                  end
               end
               ST_DATA: begin
                  din_q <= {din_q[14:0], sdi_s};
                  cnt_q <= cnt_q + 5'd1;
                  if (cnt_q == dat_last) begin
                     st_q    <= ST_HOLD;
                     armed_q <= 1'b1;
                  end
               end
               ST_READ: begin
                  if (bidx_q == '0) begin
                     sdo_q  <= word[15];
                     obuf_q <= {word[14:0], 1'b0};
                  end else begin
                     sdo_q  <= obuf_q[15];
                     obuf_q <= {obuf_q[14:0], 1'b0};
                  end
                  if (bidx_q == rd_last) begin
                     bidx_q <= '0;
                     addr_q <= (addr_q + 1'b1) & addr_mask;
                  end else begin
                     bidx_q <= bidx_q + 4'd1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // ---------------- storage and cycle timer ----------------
   logic        ar_all;
   logic [15:0] ar_wdata;
   assign ar_all   = (job_q == JOB_CLR_ALL) || (job_q == JOB_PROG_ALL);
   assign ar_wdata = ((job_q == JOB_CLR) || (job_q == JOB_CLR_ALL)) ? 16'hFFFF : din_q;

   uwe_array #(.NBYTES(NBYTES)) u_array (
      .clk(clk), .rst_n(rst_n), .wide_i(wide), .we_i(start), .all_i(ar_all),
      .addr_i(addr_q), .wdata_i(ar_wdata), .rdata_o(word));

   uwe_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy));

   assign sdo_o    = stat_q ? ~busy : sdo_q;
   assign sdo_en_o = cs_s & (stat_q | rd_on_q);

   // ---------------- assertions ----------------
   // R4: a timed operation only ever begins with the latch set
   p_cycle_needs_wen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> wen_q);
   // R9: the status indication cannot be dismissed during the busy period
   p_flag_kept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && stat_q) |=> stat_q);
   // R10: no frame is accepted while busy
   p_idle_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && st_q == ST_IDLE) |=> (st_q == ST_IDLE));
   // R3: the read pointer stays inside the 64-word space in wide mode
   p_wide_addr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wide && st_q == ST_READ) |-> !addr_q[NAW-1]);
endmodule

// File: tb/uwire_eeprom_tb_top.sv
module uwire_eeprom_tb_top;
   localparam int CLK_NS = 10;
   localparam int HALF   = 4;
   localparam int CYC    = 400;

   logic clk = 1'b0, rst_n = 1'b0, wide = 1'b1, cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
   logic sdo, sdo_en;
   int   nchk = 0, nerr = 0, cslow = 0;
   logic s_o, s_e;
   logic [7:0] ref_mem [128];
   bit   ref_wen = 0;

   always #(CLK_NS/2) clk = ~clk;

   uwire_eeprom #(.CYCLE_CLKS(CYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .wide_mode_i(wide), .cs_i(cs), .sclk_i(sclk),
      .sdi_i(sdi), .sdo_o(sdo), .sdo_en_o(sdo_en));

   task automatic tick(input int n); repeat (n) @(negedge clk); endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // R11 monitor on every clock
   always @(negedge clk) begin
      if (!cs) cslow++; else cslow = 0;
      if (rst_n && cslow >= 4) chk("R11 enable low with cs low", {15'd0, sdo_en}, 16'd0);
   end

   function automatic int aw();  return wide ? 6 : 7;    endfunction
   function automatic int dw();  return wide ? 16 : 8;   endfunction
   function automatic int nw();  return wide ? 64 : 128; endfunction
   function automatic logic [15:0] ref_word(input int a);
      return wide ? {ref_mem[2*a], ref_mem[2*a+1]} : {8'h00, ref_mem[a]};
   endfunction
   task automatic ref_put(input int a, input logic [15:0] d);
      if (wide) begin ref_mem[2*a] = d[15:8]; ref_mem[2*a+1] = d[7:0]; end
      else ref_mem[a] = d[7:0];
   endtask

   task automatic sbit(input logic b);
      sdi = b; tick(HALF); sclk = 1'b1; tick(HALF);
      s_o = sdo; s_e = sdo_en; sclk = 1'b0;
   endtask
   task automatic sel();   cs = 1'b1; tick(HALF); endtask
   task automatic desel(); sclk = 1'b0; cs = 1'b0; tick(HALF + 2); endtask
   task automatic hdr(input logic [1:0] op, input int a);
      sbit(1'b1); sbit(op[1]); sbit(op[0]);
      for (int i = aw() - 1; i >= 0; i--) sbit(a[i]);
   endtask
   task automatic sdata(input logic [15:0] d);
      for (int i = dw() - 1; i >= 0; i--) sbit(d[i]);
   endtask
   task automatic ext(input int sub); hdr(2'b00, sub << (aw() - 2)); endtask

   task automatic finish_op(input bit cyc, input string req);
      sel();
      if (cyc) begin
         chk({req, " busy status"}, {14'd0, sdo_en, sdo}, 16'b10);
         tick(CYC + 20);
         chk({req, " ready status"}, {14'd0, sdo_en, sdo}, 16'b11);
         sbit(1'b1);
         chk({req, " status off after 1 (R9)"}, {15'd0, s_e}, 16'd0);
      end else begin
         chk({req, " no operation started"}, {15'd0, sdo_en}, 16'd0);
      end
      desel();
   endtask

   task automatic rd(input int a, input int n, input int lead, input string req);
      int ad = a;
      sel();
      for (int i = 0; i < lead; i++) sbit(1'b0);
      hdr(2'b10, ad);
      chk({req, " dummy bit (R2)"}, {14'd0, s_e, s_o}, 16'b10);
      for (int w = 0; w < n; w++) begin
         logic [15:0] got = '0;
         logic        en_ok = 1'b1;
         for (int i = 0; i < dw(); i++) begin
            sbit(1'b0);
            got = {got[14:0], s_o};
            en_ok = en_ok & s_e;
         end
         chk({req, " read word"}, got, ref_word(ad));
         chk({req, " read enable"}, {15'd0, en_ok}, 16'd1);
         ad = (ad + 1) % nw();
      end
      desel();
   endtask

   task automatic wr(input int a, input logic [15:0] d, input string req);
      bit c = ref_wen;
      sel(); hdr(2'b01, a); sdata(d); desel();
      if (c) ref_put(a, d);
      finish_op(c, req);
   endtask
   task automatic er(input int a, input string req);
      bit c = ref_wen;
      sel(); hdr(2'b11, a); desel();
      if (c) ref_put(a, 16'hFFFF);
      finish_op(c, req);
   endtask
   task automatic unlock(); sel(); ext(3); desel(); ref_wen = 1; endtask
   task automatic lock();   sel(); ext(0); desel(); ref_wen = 0; endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      for (int i = 0; i < 128; i++) ref_mem[i] = 8'hFF;
      tick(5); rst_n = 1'b1; tick(5);
      chk("R11 reset enable", {15'd0, sdo_en}, 16'd0);

      // R4: latch clear after reset, program is refused
      wr(5, 16'h1234, "R4 locked after reset");
      rd(5, 1, 0, "R4 word untouched");

      unlock();
      wr(5, 16'hA55A, "R5 program");
      rd(5, 1, 2, "R1 leading zeros then read");
      wr(6, 16'h0F0F, "R5 program");
      wr(7, 16'h8001, "R5 program");
      rd(5, 3, 0, "R3 sequential");
      wr(5, 16'h1234, "R5 overwrite without clear");
      rd(5, 1, 0, "R5 overwrite");
      er(6, "R6 clear word");
      rd(6, 1, 0, "R6 clear word");
      wr(63, 16'hBEEF, "R5 program top");
      rd(63, 2, 0, "R3 wide wrap");

      // R10 / R9: frame during busy is ignored, a 1 while busy keeps status
      sel(); hdr(2'b01, 10); sdata(16'h1111); desel();
      ref_put(10, 16'h1111);
      sel();
      chk("R8 busy after start", {14'd0, sdo_en, sdo}, 16'b10);
      hdr(2'b11, 10);
      chk("R9 one while busy ignored", {14'd0, s_e, s_o}, 16'b10);
      desel();
      tick(CYC);
      sel();
      chk("R8 ready", {14'd0, sdo_en, sdo}, 16'b11);
      sbit(1'b1);
      chk("R9 status off", {15'd0, s_e}, 16'd0);
      desel();
      rd(10, 1, 0, "R10 busy frame ignored");

      // R10: truncated frame
      sel(); hdr(2'b01, 10); for (int i = 0; i < 8; i++) sbit(1'b0); desel();
      finish_op(0, "R10 truncated frame");
      rd(10, 1, 0, "R10 truncated frame");

      // R4: lock then attempt program and clear
      lock();
      wr(10, 16'h2222, "R4 locked program");
      er(5, "R4 locked clear");
      rd(10, 1, 0, "R4 locked program");
      rd(5, 1, 0, "R4 locked clear");

      // R7: program all, clear all
      unlock();
      sel(); ext(1); sdata(16'h5A5A); desel();
      for (int a = 0; a < 64; a++) ref_put(a, 16'h5A5A);
      finish_op(1, "R7 program all");
      rd(0, 2, 0, "R7 program all");
      rd(40, 1, 0, "R7 program all");
      sel(); ext(2); desel();
      for (int i = 0; i < 128; i++) ref_mem[i] = 8'hFF;
      finish_op(1, "R7 clear all");
      rd(20, 1, 0, "R7 clear all");

      // R1 / R3: narrow organization
      wide = 1'b0; tick(4);
      wr(127, 16'h003C, "R1 narrow program");
      wr(0, 16'h00C3, "R1 narrow program");
      rd(127, 2, 0, "R3 narrow wrap");
      rd(1, 1, 0, "R1 narrow neighbour");

      tick(10);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule